// File: doc/BRIEF.md
# GF(2^128) Streaming Multiplier

This block multiplies pairs of elements of the binary field GF(2^128). An element is a 128-bit word in which bit i is the coefficient of x^i. Each accepted operand pair is multiplied carry-lessly into a 256-bit polynomial product. The product is built from three 64x64 carry-less multiplies of the operand halves. It is then folded back to 128 bits modulo x^128 + x^7 + x^2 + x + 1. The low part of that polynomial is the constant 0x87.

Operands arrive on a valid/ready input and results leave on a valid/ready output. A pair is taken on a clock edge where `in_valid` and `in_ready` are both high. A result is handed over on an edge where `out_valid` and `out_ready` are both high. The block is a two-stage pipeline: the first stage registers the full product and the second registers the reduced result. Both stages move together. `in_ready` is high exactly when the output register is empty or is being read in the same cycle. Back-pressure on the output therefore stalls the whole pipe and the input. Results leave in acceptance order, one per accepted pair.

Top module: `gfm_stream_mul`

## Requirements
- R1: `out_prod` equals a·b reduced modulo x^128 + x^7 + x^2 + x + 1, with bit i of every word the coefficient of x^i. This includes products that reach degree 254, such as x^127·x^127 = 0xC000...0000_1067, and x^127·x = 0x87.
- R2: Small operands give their plain carry-less product. For example, 7·3 = 9.
- R3: When the unreduced product has degree below 128, `out_prod` equals that product unchanged. For example, (2^64−1)·2 = 0x1_FFFF_FFFF_FFFF_FFFE.
- R4: When one operand is 1, the result is the other operand.
- R5: When either operand is 0, the result is 0.
- R6: While `out_valid` is high and `out_ready` is low, `out_prod` holds its value, `out_valid` stays high, and `in_ready` is low.
- R7: Results leave in the order their pairs were accepted, exactly one per accepted pair, under any pattern of input gaps and output stalls.
- R8: Reset clears both stages. After reset, `out_valid` is low and `in_ready` is high. A pair accepted on edge k, with no stall, shows `out_valid` high after edge k+1 and not after edge k.
- R9: Field addition is bitwise XOR, and the product distributes over it: a·(b XOR c) = a·b XOR a·c.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand pair present |
| in_ready | output | 1 | Block takes the pair on this edge |
| in_a | input | 128 | First operand |
| in_b | input | 128 | Second operand |
| out_valid | output | 1 | Reduced product present |
| out_ready | input | 1 | Consumer takes the product on this edge |
| out_prod | output | 128 | Reduced product a·b |

## Verification
On every cycle, the assertions check the stall rules: the output holds and the input is blocked while the consumer refuses. They check that a first-stage entry always moves on when the pipe advances. They also check that a zero operand or a unit operand gives the expected unreduced product, and that a product with an empty upper half passes through the fold unchanged. Only the bench's scenarios can show the arithmetic itself: products checked against an independent bit-serial multiply-and-reduce model, the degree-254 corner, and distributivity over XOR. They also cover ordering and completeness of a stream driven with input gaps and an irregular output stall pattern, and the exact cycle in which a result first appears.

// File: rtl/gfm_pkg.sv
package gfm_pkg;
  localparam int unsigned GFM_W    = 128;
  localparam int unsigned GFM_HALF = GFM_W / 2;
  // Low-order terms of x^128 + x^7 + x^2 + x + 1 (x^128 is implicit)
  localparam logic [GFM_W-1:0] GFM_POLY_LOW = 128'h87;
endpackage

// File: rtl/gfm_clmul.sv
// Carry-less W x W -> 2W multiplier: XOR of shifted partial rows.
module gfm_clmul #(
  parameter int unsigned W = 64
) (
  input  logic [W-1:0]   op_x,
  input  logic [W-1:0]   op_y,
  output logic [2*W-1:0] prod
);
  localparam int unsigned PW = 2 * W;

  logic [PW-1:0] acc [W+1];
  assign acc[0] = '0;

  for (genvar i = 0; i < W; i++) begin : g_row
    logic [PW-1:0] row;
    assign row        = ({{W{1'b0}}, op_x} << i) & {PW{op_y[i]}};
    assign acc[i + 1] = acc[i] ^ row;
  end

  assign prod = acc[W];
endmodule

// File: rtl/gfm_karatsuba.sv
// W x W carry-less product from three half-width products.
module gfm_karatsuba #(
  parameter int unsigned W = 128
) (
  input  logic [W-1:0]   op_a,
  input  logic [W-1:0]   op_b,
  output logic [2*W-1:0] full
);
  localparam int unsigned H = W / 2;

  logic [H-1:0] a_lo, a_hi, b_lo, b_hi;
  logic [W-1:0] p_lo, p_hi, p_mix, p_mid;

  assign a_lo = op_a[H-1:0];
  assign a_hi = op_a[W-1:H];
  assign b_lo = op_b[H-1:0];
  assign b_hi = op_b[W-1:H];

  gfm_clmul #(.W(H)) u_mul_lo  (.op_x(a_lo),        .op_y(b_lo),        .prod(p_lo));
  gfm_clmul #(.W(H)) u_mul_hi  (.op_x(a_hi),        .op_y(b_hi),        .prod(p_hi));
  gfm_clmul #(.W(H)) u_mul_mix (.op_x(a_lo ^ a_hi), .op_y(b_lo ^ b_hi), .prod(p_mix));

  // cross term = (a_lo+a_hi)(b_lo+b_hi) - lo*lo - hi*hi  (all XOR)
  assign p_mid = p_mix ^ p_lo ^ p_hi;

  assign full = {p_hi, p_lo} ^ {{H{1'b0}}, p_mid, {H{1'b0}}};
endmodule

// File: rtl/gfm_fold_reduce.sv
// Two-pass fold of a 2W-bit product modulo x^W + POLY_LOW.
// Exact when the degree of POLY_LOW is below W/2 and bit 0 is set.
module gfm_fold_reduce #(
  parameter int unsigned     W        = 128,
  parameter logic [W-1:0]    POLY_LOW = 128'h87
) (
  input  logic [2*W-1:0] wide,
  output logic [W-1:0]   narrow
);
  logic [W-1:0] upper, lower, spill;

  assign upper = wide[2*W-1:W];
  assign lower = wide[W-1:0];

  // First pass: bring down the bits that overflow past x^W again.
  always_comb begin
    spill = upper;
    for (int t = 1; t < W; t++) begin
      if (POLY_LOW[t]) spill = spill ^ (upper >> (W - t));
    end
  end

  // Second pass: multiply spill by POLY_LOW, truncate, add low word.
  always_comb begin
    narrow = lower ^ spill;
    for (int t = 1; t < W; t++) begin
      if (POLY_LOW[t]) narrow = narrow ^ (spill << t);
    end
  end
endmodule

// File: rtl/gfm_stream_mul.sv
module gfm_stream_mul
  import gfm_pkg::*;
#(
  parameter int unsigned  W        = GFM_W,
  parameter logic [W-1:0] POLY_LOW = GFM_POLY_LOW
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_a,
  input  logic [W-1:0] in_b,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_prod
);
  localparam int unsigned PW = 2 * W;

  logic          advance;
  logic          s1_vld;
  logic [PW-1:0] s1_prod;
  logic [PW-1:0] full_prod;
  logic [W-1:0]  folded;

  gfm_karatsuba #(.W(W)) u_kara (
    .op_a (in_a),
    .op_b (in_b),
    .full (full_prod)
  );

  gfm_fold_reduce #(.W(W), .POLY_LOW(POLY_LOW)) u_fold (
    .wide   (s1_prod),
    .narrow (folded)
  );

  // Whole pipe moves when the output slot is free or being drained.
  assign advance  = !out_valid || out_ready;
  assign in_ready = advance;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_vld    <= 1'b0;
      out_valid <= 1'b0;
    end else if (advance) begin
      s1_vld    <= in_valid;
      out_valid <= s1_vld;
    end
  end

  always_ff @(posedge clk) begin
    if (advance && in_valid) s1_prod  <= full_prod;
    if (advance && s1_vld)   out_prod <= folded;
  end

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_prod)); // R6
  AST_IN_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready); // R6
  AST_PIPE_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
    s1_vld && advance |=> out_valid); // R8
  AST_ZERO_OPERAND: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && (in_a == '0 || in_b == '0) |=> s1_prod == '0); // R5
  AST_UNIT_OPERAND: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_b == {{(W-1){1'b0}}, 1'b1}
    |=> s1_prod == {{W{1'b0}}, $past(in_a)}); // R4
  AST_NO_FOLD: assert property (@(posedge clk) disable iff (!rst_n)
    s1_vld && advance && s1_prod[PW-1:W] == '0
    |=> out_prod == $past(s1_prod[W-1:0])); // R3
endmodule

// File: tb/gfm_stream_mul_bench.sv
module gfm_stream_mul_bench;
  localparam int W  = 128;
  localparam int NT = 7;
  localparam int NS = 24;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [W-1:0] in_a = '0;
  logic [W-1:0] in_b = '0;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [W-1:0] out_prod;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  gfm_stream_mul u_gfm_stream_mul (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_a(in_a), .in_b(in_b),
    .out_valid(out_valid), .out_ready(out_ready), .out_prod(out_prod)
  );

  // {a, b, expected}
  localparam logic [3*W-1:0] TBL [NT] = '{
    {128'h7, 128'h3, 128'h9},                                               // R2
    {128'h1, 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210,
             128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210},                 // R4
    {128'h5555_5555_5555_5555_5555_5555_5555_5555, 128'h0, 128'h0},        // R5
    {128'h8000_0000_0000_0000_0000_0000_0000_0000, 128'h2, 128'h87},        // R1
    {128'h8000_0000_0000_0000_0000_0000_0000_0000,
     128'h8000_0000_0000_0000_0000_0000_0000_0000,
     128'hC000_0000_0000_0000_0000_0000_0000_1067},                         // R1
    {128'h1_0000_0000_0000_0000, 128'h1_0000_0000_0000_0000, 128'h87},      // R1
    {128'hFFFF_FFFF_FFFF_FFFF, 128'h2, 128'h1_FFFF_FFFF_FFFF_FFFE}          // R3
  };

  // Bit-serial multiply-and-reduce model (Horner over bits of b).
  function automatic logic [W-1:0] gf_ref(input logic [W-1:0] a, input logic [W-1:0] b);
    logic [W-1:0] r;
    r = '0;
    for (int i = W - 1; i >= 0; i--) begin
      r = {r[W-2:0], 1'b0} ^ (r[W-1] ? 128'h87 : 128'h0);
      if (b[i]) r = r ^ a;
    end
    return r;
  endfunction

  function automatic logic [W-1:0] pat(input int i, input int s);
    logic [W-1:0] v;
    for (int k = 0; k < 4; k++)
      v[32*k +: 32] = (i * 32'h9E37_79B9) ^ (s * 32'h85EB_CA6B) ^ (k * 32'hC2B2_AE35) ^ 32'h2718_2818;
    return v;
  endfunction

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // One pair with the output always ready; returns the product.
  task automatic run_one(input logic [W-1:0] a, input logic [W-1:0] b, output logic [W-1:0] r);
    @(negedge clk);
    in_valid = 1'b1; in_a = a; in_b = b; out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    #2;
    r = out_prod;
  endtask

  logic [W-1:0] sa [NS];
  logic [W-1:0] sb [NS];

  initial begin
    logic [W-1:0] r, r1, r2, r3, held;
    repeat (3) @(negedge clk);
    chk("R8 reset out_valid", {127'b0, out_valid}, 128'h0);
    chk("R8 reset in_ready",  {127'b0, in_ready},  128'h1);
    rst_n = 1'b1;

    // table walk
    for (int k = 0; k < NT; k++) begin
      run_one(TBL[k][3*W-1:2*W], TBL[k][2*W-1:W], r);
      chk($sformatf("R1 table %0d vs hand value", k), r, TBL[k][W-1:0]);
      chk($sformatf("R1 table %0d vs model", k), r, gf_ref(TBL[k][3*W-1:2*W], TBL[k][2*W-1:W]));
    end

    // all-ones corner and 2^127 times all-ones
    run_one({W{1'b1}}, {W{1'b1}}, r);
    chk("R1 ones*ones", r, gf_ref({W{1'b1}}, {W{1'b1}}));
    run_one(128'h8000_0000_0000_0000_0000_0000_0000_0000, {W{1'b1}}, r);
    chk("R1 msb*ones", r, gf_ref(128'h8000_0000_0000_0000_0000_0000_0000_0000, {W{1'b1}}));
    run_one(pat(3, 1), 128'h1, r);
    chk("R4 a*1", r, pat(3, 1));
    run_one(128'h0, pat(4, 2), r);
    chk("R5 0*b", r, 128'h0);

    // R9 distributivity over XOR
    run_one(pat(5, 1), pat(6, 2) ^ pat(7, 3), r1);
    run_one(pat(5, 1), pat(6, 2), r2);
    run_one(pat(5, 1), pat(7, 3), r3);
    chk("R9 a(b^c)=ab^ac", r1, r2 ^ r3);

    // R8 latency: result not visible after one edge, visible after two
    @(negedge clk);
    in_valid = 1'b1; in_a = pat(8, 1); in_b = pat(9, 2); out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    #2;
    chk("R8 not after first edge", {127'b0, out_valid}, 128'h0);
    @(negedge clk);
    #2;
    chk("R8 valid after second edge", {127'b0, out_valid}, 128'h1);
    chk("R8 value", out_prod, gf_ref(pat(8, 1), pat(9, 2)));

    // R6 stall: two pairs in with output blocked
    @(negedge clk);
    out_ready = 1'b0; in_valid = 1'b1; in_a = pat(10, 1); in_b = pat(11, 2);
    @(negedge clk);
    in_a = pat(12, 1); in_b = pat(13, 2);
    @(negedge clk);
    in_valid = 1'b0;
    #2;
    held = out_prod;
    chk("R6 stalled output valid", {127'b0, out_valid}, 128'h1);
    chk("R6 input blocked", {127'b0, in_ready}, 128'h0);
    repeat (3) @(negedge clk);
    #2;
    chk("R6 output held", out_prod, held);
    chk("R6 held value", held, gf_ref(pat(10, 1), pat(11, 2)));
    @(negedge clk);
    out_ready = 1'b1;
    @(negedge clk);
    #2;
    chk("R7 second after stall", out_prod, gf_ref(pat(12, 1), pat(13, 2)));
    @(negedge clk);
    #2;
    chk("R7 drained", {127'b0, out_valid}, 128'h0);

    // R7 stream with input gaps and irregular back-pressure
    for (int i = 0; i < NS; i++) begin
      sa[i] = pat(i + 20, 5);
      sb[i] = (i % 5 == 2) ? 128'h1 : pat(i + 40, 6);
    end
    fork
      begin
        int p = 0;
        int c = 0;
        while (p < NS) begin
          @(negedge clk);
          c++;
          in_valid = (c % 7) != 3;
          in_a = sa[p]; in_b = sb[p];
          #2;
          if (in_valid && in_ready) p++;
        end
        @(negedge clk);
        in_valid = 1'b0;
      end
      begin
        int q = 0;
        int c = 0;
        while (q < NS) begin
          @(negedge clk);
          c++;
          out_ready = (c % 3) != 1;
          #2;
          if (out_valid && out_ready) begin
            chk($sformatf("R7 stream item %0d", q), out_prod, gf_ref(sa[q], sb[q]));
            q++;
          end
        end
        out_ready = 1'b1;
      end
    join
    repeat (4) @(negedge clk);
    #2;
    chk("R7 no extra result", {127'b0, out_valid}, 128'h0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule